// File: doc/BRIEF.md
# Complementary Deadtime Stage with Burst Idle

This block drives a pair of complementary PWM pins from one reference waveform. In normal running, channel A follows the reference and channel B follows its complement. Each channel is held low for a programmable number of clock cycles after the reference edge that would turn it on, so the two channels are never high together. A global enable bypasses the deadtime and lets the pins follow the reference and its inverse directly. Every pin is registered, so each output takes the value computed from the inputs sampled at one rising clock edge.

A burst-entry pulse moves the stage into an idle state, and each pin then goes to its own programmed idle level. Each channel also has its own delayed-idle option. When that option takes effect, the pin is first held low for that channel's own deadtime and only then goes to its idle level. A burst entry that arrives while a normal deadtime is still counting abandons that count and starts a fresh one. A burst-exit pulse ends the burst, but the pins keep their idle levels until the next reference edge, and normal deadtime operation resumes at that edge.

Top module: `dt_burst_stage`

## Requirements
- R1: While reset is asserted, both pins and the idle flag are 0.
- R2: When the deadtime enable is 0 and the stage is running, after each clock edge channel A equals the sampled reference and channel B equals its complement.
- R3: When the deadtime enable is 1, channel A rises N edges later than it would with no deadtime, where N is the effective rise deadtime. The count starts at the edge that samples the reference rising.
- R4: When the deadtime enable is 1, channel B rises N edges after the edge that samples the reference falling, where N is the effective fall deadtime. A channel drops at the same edge that samples its reference phase ending.
- R5: Each effective deadtime is the programmed 9-bit value, or 3 if the programmed value is smaller than 3. This rule also applies to delayed idle.
- R6: A burst entry sampled while running drives each channel whose delayed idle is not in effect straight to its idle level at that same edge (idle_lvl bit 0 goes to channel A, bit 1 to channel B).
- R7: If delayed idle is in effect for a channel, that channel is low for its effective deadtime after entry and then takes its idle level. Channel A (dly_idle_en bit 0) uses the rise deadtime, and channel B (bit 1) uses the fall deadtime.
- R8: A delayed-idle enable is in effect only if at least one idle_lvl bit is 1 and both sign inputs are 0. Otherwise entry behaves as in R6.
- R9: A burst entry during a running deadtime cancels that count, and the delay restarts in full from the entry edge.
- R10: After a burst exit, the pins hold their idle levels until an edge that samples the reference changed. At that edge the flag drops and deadtime processing resumes.
- R11: The idle flag rises at the edge that samples a burst entry and stays high through the delay, the idle state and the wait after exit.
- R12: While the idle flag is 0, the two channels are never both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_pwm | input | 1 | Reference PWM waveform |
| dt_en | input | 1 | Deadtime insertion enable |
| burst_enter | input | 1 | Burst entry pulse |
| burst_exit | input | 1 | Burst exit pulse |
| idle_lvl | input | 2 | Idle level per channel (bit 0 = A, bit 1 = B) |
| dly_idle_en | input | 2 | Delayed-idle enable per channel |
| dt_rise | input | 9 | Rise deadtime in cycles (channel A) |
| dt_fall | input | 9 | Fall deadtime in cycles (channel B) |
| dt_rise_neg | input | 1 | Rise deadtime sign, 1 = negative |
| dt_fall_neg | input | 1 | Fall deadtime sign, 1 = negative |
| ch_a | output | 1 | Channel A pin |
| ch_b | output | 1 | Channel B pin |
| idle_flag | output | 1 | High while not in normal running |

## Verification
A channel counter that is loaded with the wrong value shows up as a pin edge that comes too early or too late. The error appears within N cycles of the reference edge or burst entry that loaded the counter, so the bench samples every cycle around those edges. A wrong burst state shows at the idle flag on the very next edge. It also shows at the pins if they leave their idle levels before a reference edge after an exit. A wrong delayed-idle qualification shows on the first edge after entry, as a pin at its idle level where it should be low, or the reverse.

// File: rtl/dtb_pkg.sv
package dtb_pkg;
  localparam int unsigned MIN_DT = 3;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_BURST = 2'd1,
    ST_WAIT  = 2'd2
  } bst_t;
endpackage

// File: rtl/dtb_burst_ctl.sv
module dtb_burst_ctl
  import dtb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  input  logic enter,
  input  logic leave,
  output logic ref_q,
  output logic load,
  output logic hold,
  output logic in_idle
);
  bst_t st_q, st_n;
  logic edge_seen, resume;

  assign edge_seen = ref_in ^ ref_q;
  assign load      = (st_q == ST_RUN) && enter;
  assign resume    = (st_q == ST_WAIT) && !enter && edge_seen;
  assign hold      = (st_q != ST_RUN) && !resume;
  assign in_idle   = (st_q != ST_RUN);

  always_comb begin
    st_n = st_q;
    case (st_q)
      ST_RUN:   if (enter) st_n = ST_BURST;
      ST_BURST: if (leave) st_n = ST_WAIT;
      ST_WAIT: begin
        if (enter)          st_n = ST_BURST;
        else if (edge_seen) st_n = ST_RUN;
      end
      default:  st_n = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_RUN;
      ref_q <= 1'b0;
    end else begin
      st_q  <= st_n;
      ref_q <= ref_in;
    end
  end
endmodule

// File: rtl/dtb_chan.sv
module dtb_chan
  import dtb_pkg::*;
#(
  parameter int unsigned DT_W = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dt_on,
  input  logic            want,
  input  logic            start,
  input  logic            load,
  input  logic            dsel,
  input  logic            hold,
  input  logic            idle_val,
  input  logic [DT_W-1:0] dt_val,
  output logic            pin
);
  localparam logic [DT_W-1:0] MIN_V = DT_W'(MIN_DT);

  logic [DT_W-1:0] eff, cnt_q, cnt_n;
  logic            pin_n, pin_q;

  assign eff = (dt_val < MIN_V) ? MIN_V : dt_val;
  assign pin = pin_q;

  always_comb begin
    cnt_n = cnt_q;
    pin_n = pin_q;
    if (load) begin
      cnt_n = dsel ? (eff - 1'b1) : '0;
      pin_n = dsel ? 1'b0 : idle_val;
    end else if (hold) begin
      if (cnt_q != '0) begin
        cnt_n = cnt_q - 1'b1;
        pin_n = 1'b0;
      end else begin
        pin_n = idle_val;
      end
    end else if (!dt_on) begin
      cnt_n = '0;
      pin_n = want;
    end else if (start) begin
      cnt_n = eff - 1'b1;
      pin_n = 1'b0;
    end else if (!want) begin
      cnt_n = '0;
      pin_n = 1'b0;
    end else if (cnt_q != '0) begin
      cnt_n = cnt_q - 1'b1;
      pin_n = 1'b0;
    end else begin
      pin_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pin_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      pin_q <= pin_n;
    end
  end
endmodule

// File: rtl/dt_burst_stage.sv
module dt_burst_stage #(
  parameter int unsigned DT_W = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ref_pwm,
  input  logic            dt_en,
  input  logic            burst_enter,
  input  logic            burst_exit,
  input  logic [1:0]      idle_lvl,
  input  logic [1:0]      dly_idle_en,
  input  logic [DT_W-1:0] dt_rise,
  input  logic [DT_W-1:0] dt_fall,
  input  logic            dt_rise_neg,
  input  logic            dt_fall_neg,
  output logic            ch_a,
  output logic            ch_b,
  output logic            idle_flag
);
  localparam int unsigned NCH = 2;

  logic            ref_q, load, hold, dly_ok;
  logic [NCH-1:0]  want, start, dsel, pins;
  logic [DT_W-1:0] dtv [NCH];

  dtb_burst_ctl u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .ref_in  (ref_pwm),
    .enter   (burst_enter),
    .leave   (burst_exit),
    .ref_q   (ref_q),
    .load    (load),
    .hold    (hold),
    .in_idle (idle_flag)
  );

  assign dly_ok   = (|idle_lvl) && !dt_rise_neg && !dt_fall_neg;
  assign want[0]  = ref_pwm;
  assign want[1]  = !ref_pwm;
  assign start[0] = ref_pwm && !ref_q;
  assign start[1] = !ref_pwm && ref_q;
  assign dtv[0]   = dt_rise;
  assign dtv[1]   = dt_fall;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign dsel[i] = dly_idle_en[i] && dly_ok;
    dtb_chan #(.DT_W(DT_W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .dt_on    (dt_en),
      .want     (want[i]),
      .start    (start[i]),
      .load     (load),
      .dsel     (dsel[i]),
      .hold     (hold),
      .idle_val (idle_lvl[i]),
      .dt_val   (dtv[i]),
      .pin      (pins[i])
    );
  end

  assign ch_a = pins[0];
  assign ch_b = pins[1];
endmodule

// File: rtl/dt_burst_chk.sv
module dt_burst_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ref_pwm,
  input logic       dt_en,
  input logic       burst_enter,
  input logic [1:0] idle_lvl,
  input logic [1:0] dly_idle_en,
  input logic       dt_rise_neg,
  input logic       dt_fall_neg,
  input logic       ch_a,
  input logic       ch_b,
  input logic       idle_flag
);
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !idle_flag |-> !(ch_a && ch_b)); // R12

  AST_FLAG_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!idle_flag && burst_enter) |-> idle_flag); // R11

  AST_IMM_IDLE_A: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(idle_flag) && !$past(dly_idle_en[0])) |-> (ch_a == $past(idle_lvl[0]))); // R6

  AST_DLY_LOW_A: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(idle_flag) && $past(dly_idle_en[0] && (|idle_lvl) && !dt_rise_neg && !dt_fall_neg))
      |-> !ch_a); // R7

  AST_DLY_LOW_B: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(idle_flag) && $past(dly_idle_en[1] && (|idle_lvl) && !dt_rise_neg && !dt_fall_neg))
      |-> !ch_b); // R7

  AST_RESUME_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(idle_flag) |-> ($past(ref_pwm) != $past(ref_pwm, 2))); // R10

  AST_DT_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ch_a) && !idle_flag && $past(dt_en) && $past(dt_en, 2) && $past(dt_en, 3))
      |-> ($past(ref_pwm) && $past(ref_pwm, 2) && $past(ref_pwm, 3))); // R5
endmodule

bind dt_burst_stage dt_burst_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ref_pwm     (ref_pwm),
  .dt_en       (dt_en),
  .burst_enter (burst_enter),
  .idle_lvl    (idle_lvl),
  .dly_idle_en (dly_idle_en),
  .dt_rise_neg (dt_rise_neg),
  .dt_fall_neg (dt_fall_neg),
  .ch_a        (ch_a),
  .ch_b        (ch_b),
  .idle_flag   (idle_flag)
);

// File: tb/tb_dt_burst_stage.sv
`timescale 1ns/1ps
module tb_dt_burst_stage;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ref_pwm, dt_en, burst_enter, burst_exit;
  logic [1:0] idle_lvl, dly_idle_en;
  logic [8:0] dt_rise, dt_fall;
  logic       dt_rise_neg, dt_fall_neg;
  logic       ch_a, ch_b, idle_flag;
  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  dt_burst_stage dut (
    .clk(clk), .rst_n(rst_n), .ref_pwm(ref_pwm), .dt_en(dt_en),
    .burst_enter(burst_enter), .burst_exit(burst_exit),
    .idle_lvl(idle_lvl), .dly_idle_en(dly_idle_en),
    .dt_rise(dt_rise), .dt_fall(dt_fall),
    .dt_rise_neg(dt_rise_neg), .dt_fall_neg(dt_fall_neg),
    .ch_a(ch_a), .ch_b(ch_b), .idle_flag(idle_flag)
  );

  // Row: {ref, dt_en, enter, exit, exp_a, exp_b, exp_flag}
  // rise = 4, fall = 2 (effective 3), idle_lvl = 01, delayed idle on both
  localparam int NV = 27;
  localparam logic [6:0] VEC [NV] = '{
    7'b0100_010, 7'b1100_000, 7'b1100_000, 7'b1100_000, 7'b1100_000,
    7'b1100_100, 7'b0100_000, 7'b0100_000, 7'b0100_000, 7'b0100_010,
    7'b1100_000, 7'b1110_001, 7'b1100_001, 7'b1100_001, 7'b1100_001,
    7'b1100_101, 7'b0101_101, 7'b0100_101, 7'b1100_000, 7'b1100_000,
    7'b1100_000, 7'b1100_000, 7'b1100_100, 7'b0000_010, 7'b1000_100,
    7'b0000_010, 7'b0110_001
  };

  task automatic chk(input string tag, input logic [2:0] got, input logic [2:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got {a,b,flag}=%b expected %b", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    ref_pwm = 1'b0; burst_enter = 1'b0; burst_exit = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 reset state", {ch_a, ch_b, idle_flag}, 3'b000);
    rst_n = 1'b1;
  endtask

  task automatic cyc(input logic r, input logic ent);
    ref_pwm = r; burst_enter = ent; burst_exit = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(4ns * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    dt_en = 1'b1; idle_lvl = 2'b01; dly_idle_en = 2'b11;
    dt_rise = 9'd4; dt_fall = 9'd2; dt_rise_neg = 1'b0; dt_fall_neg = 1'b0;
    @(negedge clk);
    do_reset();
    for (int i = 0; i < NV; i++) begin
      ref_pwm = VEC[i][6]; dt_en = VEC[i][5];
      burst_enter = VEC[i][4]; burst_exit = VEC[i][3];
      @(negedge clk);
      chk($sformatf("R2 R3 R4 R5 R9 R10 R11 row %0d", i),
          {ch_a, ch_b, idle_flag}, VEC[i][2:0]);
    end

    // R6: no delayed idle, pins go straight to idle levels
    dt_en = 1'b1; dly_idle_en = 2'b00; idle_lvl = 2'b01;
    do_reset();
    cyc(1'b0, 1'b0); cyc(1'b0, 1'b0);
    chk("R6 before entry", {ch_a, ch_b, idle_flag}, 3'b010);
    cyc(1'b0, 1'b1);
    chk("R6 immediate idle", {ch_a, ch_b, idle_flag}, 3'b101);
    cyc(1'b0, 1'b0);
    chk("R6 idle held", {ch_a, ch_b, idle_flag}, 3'b101);

    // R8: negative rise sign cancels the delayed-idle enable
    dly_idle_en = 2'b11; dt_rise_neg = 1'b1;
    do_reset();
    cyc(1'b0, 1'b0); cyc(1'b0, 1'b1);
    chk("R8 rise sign negative", {ch_a, ch_b, idle_flag}, 3'b101);
    dt_rise_neg = 1'b0; dt_fall_neg = 1'b1;
    do_reset();
    cyc(1'b0, 1'b0); cyc(1'b0, 1'b1);
    chk("R8 fall sign negative", {ch_a, ch_b, idle_flag}, 3'b101);
    dt_fall_neg = 1'b0;

    // R7 with R5: only channel A delayed, rise value 0 gives 3 cycles
    dly_idle_en = 2'b01; idle_lvl = 2'b11; dt_rise = 9'd0;
    do_reset();
    cyc(1'b0, 1'b0); cyc(1'b0, 1'b0);
    chk("R7 before entry", {ch_a, ch_b, idle_flag}, 3'b010);
    cyc(1'b0, 1'b1);
    chk("R7 entry A delayed B idle", {ch_a, ch_b, idle_flag}, 3'b011);
    cyc(1'b0, 1'b0);
    chk("R7 R5 delay cycle 2", {ch_a, ch_b, idle_flag}, 3'b011);
    cyc(1'b0, 1'b0);
    chk("R7 R5 delay cycle 3", {ch_a, ch_b, idle_flag}, 3'b011);
    cyc(1'b0, 1'b0);
    chk("R7 R5 A reaches idle", {ch_a, ch_b, idle_flag}, 3'b111);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule